// File: doc/BRIEF.md
# Supervisor Input Conditioner

This block cleans up the asynchronous logic inputs of a window watchdog supervisor before its state machine sees them. The trigger line and the mode line each pass through a two-flop synchroniser and a short debounce filter. The outputs are stable trigger and mode levels and a one-cycle strobe on each accepted rising edge of the trigger.

Six wake-up lines pass through the same kind of synchroniser. Each of them has its own debounce filter, which is much longer than the one on the trigger and mode lines. A change on any filtered wake-up line counts as a wake-up event, whether it rises or falls. The block then reports one single-cycle event pulse, and only while the supervisor is in its long (sleep) monitoring mode, which the `long_mode` input signals.

Every filter keeps a count of consecutive cycles in which the synchronised input differs from the accepted level. When the count reaches the filter length, the new level is accepted. A cycle in which the input matches the accepted level again clears the count.

Top module: `input_conditioner`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `trig_lvl` and `mode_lvl` are 1 and `trig_rise` and `wake_evt` are 0. The wake-up lines start from an accepted level of 0.
- R2: Suppose a trigger or mode input changes between clock edges k and k+1 and then holds for SHORT_HOLD cycles. The matching level output takes the new value at edge k+2+SHORT_HOLD and not before. That is two synchroniser edges followed by SHORT_HOLD edges of mismatch.
- R3: An input pulse lasting fewer cycles than its filter length never changes the accepted level. Any cycle in which the input matches the accepted level clears the count, so the filter starts again from zero.
- R4: `trig_rise` is high for exactly one cycle, the first cycle in which `trig_lvl` reads 1 after reading 0. A falling trigger produces no strobe.
- R5: Each of the WAKE_LINES wake-up inputs has its own filter of length LONG_HOLD. A change becomes an accepted level change at edge k+2+LONG_HOLD, under the same timing rule as R2.
- R6: Suppose an accepted change on any wake-up line, rising or falling, takes effect at edge e. Then `wake_evt` is high for the one cycle after edge e+1. Changes accepted on several lines at the same edge give a single pulse.
- R7: `wake_evt` can be 1 after an edge only if `long_mode` was 1 at that edge. Wake-up changes accepted while `long_mode` is 0 are dropped and are not replayed later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Raw trigger line, idle high |
| mode_in | input | 1 | Raw mode line, idle high |
| wake_in | input | WAKE_LINES | Raw wake-up lines, idle low |
| long_mode | input | 1 | High while the long watchdog window is active |
| trig_lvl | output | 1 | Debounced trigger level |
| mode_lvl | output | 1 | Debounced mode level |
| trig_rise | output | 1 | One-cycle strobe on an accepted trigger rise |
| wake_evt | output | 1 | One-cycle wake-up event, gated by long_mode |

## Verification
The hardest situation to reach from the ports is two or more wake-up lines finishing their long filters on the same edge. A random toggle on each line almost never lines up that closely. A directed case therefore moves two lines in the same cycle and counts the event pulses that follow, and a second directed case repeats this with `long_mode` low. Random stimulus toggles the trigger and mode lines often enough to produce runs just shorter and just longer than the short filter. A bench reference model, built from the timing rules above, predicts every output in every cycle.

// File: rtl/ic_pkg.sv
package ic_pkg;
  localparam int unsigned DEF_SHORT_HOLD = 4;
  localparam int unsigned DEF_LONG_HOLD  = 128;
  localparam int unsigned DEF_WAKE_LINES = 6;

  function automatic int unsigned cnt_width(input int unsigned hold);
    return (hold > 1) ? $clog2(hold) : 1;
  endfunction
endpackage

// File: rtl/sync_2ff.sv
module sync_2ff #(
  parameter logic IDLE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= IDLE;
      dout   <= IDLE;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/deb_cell.sv
module deb_cell #(
  parameter int unsigned HOLD = 4,
  parameter logic        IDLE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic flip
);
  localparam int unsigned CW = ic_pkg::cnt_width(HOLD);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic          s;
  logic [CW-1:0] cnt;

  sync_2ff #(.IDLE(IDLE)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (din),
    .dout (s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl  <= IDLE;
      cnt  <= '0;
      flip <= 1'b0;
    end else begin
      flip <= 1'b0;
      if (s == lvl) begin
        cnt <= '0;
      end else if (cnt == LAST) begin
        lvl  <= s;
        cnt  <= '0;
        flip <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R3: a matching input holds the level and clears the count
  a_r3_match_holds: assert property (@(posedge clk) disable iff (rst)
    (s == lvl) |=> ($stable(lvl) && cnt == '0));

  // R2: a level change needs a mismatch that has reached the last count
  a_r2_accept_at_limit: assert property (@(posedge clk) disable iff (rst)
    !$stable(lvl) |-> ($past(s) != $past(lvl) && $past(cnt) == LAST));

  // R3: the count never runs past the filter length
  a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/input_conditioner.sv
module input_conditioner #(
  parameter int unsigned SHORT_HOLD = ic_pkg::DEF_SHORT_HOLD,
  parameter int unsigned LONG_HOLD  = ic_pkg::DEF_LONG_HOLD,
  parameter int unsigned WAKE_LINES = ic_pkg::DEF_WAKE_LINES
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  trig_in,
  input  logic                  mode_in,
  input  logic [WAKE_LINES-1:0] wake_in,
  input  logic                  long_mode,
  output logic                  trig_lvl,
  output logic                  mode_lvl,
  output logic                  trig_rise,
  output logic                  wake_evt
);
  logic                  trig_flip;
  logic                  mode_flip;
  logic [WAKE_LINES-1:0] wake_lvl;
  logic [WAKE_LINES-1:0] wake_flip;

  deb_cell #(.HOLD(SHORT_HOLD), .IDLE(1'b1)) u_trig (
    .clk (clk), .rst (rst), .din (trig_in), .lvl (trig_lvl), .flip (trig_flip)
  );

  deb_cell #(.HOLD(SHORT_HOLD), .IDLE(1'b1)) u_mode (
    .clk (clk), .rst (rst), .din (mode_in), .lvl (mode_lvl), .flip (mode_flip)
  );

  for (genvar i = 0; i < WAKE_LINES; i++) begin : g_wake
    deb_cell #(.HOLD(LONG_HOLD), .IDLE(1'b0)) u_wake (
      .clk  (clk),
      .rst  (rst),
      .din  (wake_in[i]),
      .lvl  (wake_lvl[i]),
      .flip (wake_flip[i])
    );
  end

  assign trig_rise = trig_flip & trig_lvl;

  always_ff @(posedge clk) begin
    if (rst) wake_evt <= 1'b0;
    else     wake_evt <= long_mode & (|wake_flip);
  end

  // R4: the strobe lasts one cycle and marks a 0 to 1 step of trig_lvl
  a_r4_rise_single: assert property (@(posedge clk) disable iff (rst)
    trig_rise |=> !trig_rise);
  a_r4_rise_on_step: assert property (@(posedge clk) disable iff (rst)
    trig_rise |-> (trig_lvl && !$past(trig_lvl)));

  // R2: a mode change pulse coincides with a change of the mode level
  a_r2_mode_flip: assert property (@(posedge clk) disable iff (rst)
    mode_flip |-> (mode_lvl != $past(mode_lvl)));

  // R7: an event only follows an edge where long mode was active
  a_r7_gated: assert property (@(posedge clk) disable iff (rst)
    wake_evt |-> $past(long_mode));

  // R6: an event always follows an accepted wake-up level change
  a_r6_follows_change: assert property (@(posedge clk) disable iff (rst)
    wake_evt |-> ($past(wake_lvl) != $past(wake_lvl, 2)));
endmodule

// File: tb/test_input_conditioner.sv
module test_input_conditioner;
  localparam int unsigned SH = 4;
  localparam int unsigned LH = 128;
  localparam int unsigned NW = 6;
  localparam int unsigned NL = NW + 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          trig_in = 1'b1;
  logic          mode_in = 1'b1;
  logic [NW-1:0] wake_in = '0;
  logic          long_mode = 1'b0;
  logic          trig_lvl, mode_lvl, trig_rise, wake_evt;

  int checks = 0;
  int errors = 0;
  bit model_on = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  input_conditioner #(.SHORT_HOLD(SH), .LONG_HOLD(LH), .WAKE_LINES(NW)) i_input_conditioner (
    .clk (clk), .rst (rst), .trig_in (trig_in), .mode_in (mode_in),
    .wake_in (wake_in), .long_mode (long_mode), .trig_lvl (trig_lvl),
    .mode_lvl (mode_lvl), .trig_rise (trig_rise), .wake_evt (wake_evt)
  );

  function automatic int unsigned hold_of(input int idx);
    return (idx < 2) ? SH : LH;
  endfunction

  function automatic bit idle_of(input int idx);
    return (idx < 2) ? 1'b1 : 1'b0;
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Reference model built from the timing rules of R2, R3, R5 and R6
  bit ms1 [NL];
  bit ms2 [NL];
  bit ml  [NL];
  int mc  [NL];
  bit m_rise, m_wchg, m_evt;

  always @(posedge clk) begin
    logic [NL-1:0] raw;
    raw = {wake_in, mode_in, trig_in};
    if (rst) begin
      for (int i = 0; i < NL; i++) begin
        ms1[i] = idle_of(i); ms2[i] = idle_of(i); ml[i] = idle_of(i); mc[i] = 0;
      end
      m_rise = 0; m_wchg = 0; m_evt = 0;
    end else begin
      m_evt  = long_mode && m_wchg;
      m_wchg = 0;
      m_rise = 0;
      for (int i = 0; i < NL; i++) begin
        if (ms2[i] == ml[i]) mc[i] = 0;
        else begin
          mc[i]++;
          if (mc[i] == int'(hold_of(i))) begin
            ml[i] = ms2[i];
            mc[i] = 0;
            if (i == 0 && ml[i]) m_rise = 1;
            if (i >= 2) m_wchg = 1;
          end
        end
        ms2[i] = ms1[i];
        ms1[i] = raw[i];
      end
    end
  end

  always @(negedge clk) begin
    if (model_on && !rst) begin
      chk("R2", "trig_lvl model", trig_lvl, ml[0]);
      chk("R2", "mode_lvl model", mode_lvl, ml[1]);
      chk("R4", "trig_rise model", trig_rise, m_rise);
      chk("R6", "wake_evt model", wake_evt, m_evt);
    end
  end

  task automatic count_evt(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wake_evt) cnt++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    bit stayed;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state while reset is held
    chk("R1", "trig_lvl in reset", trig_lvl, 1'b1);
    chk("R1", "mode_lvl in reset", mode_lvl, 1'b1);
    chk("R1", "trig_rise in reset", trig_rise, 1'b0);
    chk("R1", "wake_evt in reset", wake_evt, 1'b0);
    rst = 1'b0;
    model_on = 1'b1;
    @(negedge clk);
    chk("R1", "trig_lvl after reset", trig_lvl, 1'b1);
    chk("R1", "wake_evt after reset", wake_evt, 1'b0);
    repeat (5) @(negedge clk);

    // R2: exact latency of a trigger fall
    trig_in = 1'b0;
    repeat (SH + 1) @(negedge clk);
    chk("R2", "trig_lvl one cycle early", trig_lvl, 1'b1);
    @(negedge clk);
    chk("R2", "trig_lvl on time", trig_lvl, 1'b0);
    chk("R4", "no strobe on fall", trig_rise, 1'b0);

    // R4: strobe on rise, exactly one cycle
    trig_in = 1'b1;
    repeat (SH + 1) @(negedge clk);
    chk("R4", "no early strobe", trig_rise, 1'b0);
    @(negedge clk);
    chk("R4", "strobe present", trig_rise, 1'b1);
    chk("R2", "trig_lvl high again", trig_lvl, 1'b1);
    @(negedge clk);
    chk("R4", "strobe one cycle", trig_rise, 1'b0);

    // R2: mode line latency
    mode_in = 1'b0;
    repeat (SH + 2) @(negedge clk);
    chk("R2", "mode_lvl low", mode_lvl, 1'b0);
    mode_in = 1'b1;
    repeat (SH + 4) @(negedge clk);

    // R3: a low pulse one cycle shorter than the filter is rejected
    trig_in = 1'b0;
    repeat (SH - 1) @(negedge clk);
    trig_in = 1'b1;
    stayed = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!trig_lvl || trig_rise) stayed = 1'b0;
    end
    chk("R3", "short glitch rejected", stayed, 1'b1);

    // R5/R6: two wake lines change together, one pulse at the exact cycle
    long_mode = 1'b1;
    wake_in = 6'b001001;
    repeat (LH + 2) @(negedge clk);
    chk("R6", "no early wake event", wake_evt, 1'b0);
    @(negedge clk);
    chk("R5", "wake event on time", wake_evt, 1'b1);
    @(negedge clk);
    chk("R6", "wake event one cycle", wake_evt, 1'b0);
    count_evt(20, n);
    chk("R6", "single merged pulse", n == 0, 1'b1);

    // R7: falling wake change while long mode is off gives nothing
    long_mode = 1'b0;
    wake_in = '0;
    count_evt(LH + 10, n);
    chk("R7", "gated when long mode off", n == 0, 1'b1);
    long_mode = 1'b1;
    count_evt(10, n);
    chk("R7", "dropped event not replayed", n == 0, 1'b1);

    // R5: a wake glitch shorter than the long filter is rejected
    wake_in[4] = 1'b1;
    repeat (LH - 1) @(negedge clk);
    wake_in[4] = 1'b0;
    count_evt(LH + 10, n);
    chk("R5", "wake glitch rejected", n == 0, 1'b1);

    // R6: a falling edge on one line counts as an event
    wake_in[2] = 1'b1;
    count_evt(LH + 10, n);
    chk("R6", "rising wake event", n == 1, 1'b1);
    wake_in[2] = 1'b0;
    count_evt(LH + 10, n);
    chk("R6", "falling wake event", n == 1, 1'b1);

    // Random phase, checked each cycle against the model
    for (int c = 0; c < 40000; c++) begin
      @(negedge clk);
      if ($urandom_range(0, 7) == 0)    trig_in = ~trig_in;
      if ($urandom_range(0, 29) == 0)   mode_in = ~mode_in;
      if ($urandom_range(0, 299) == 0)  long_mode = ~long_mode;
      for (int w = 0; w < int'(NW); w++)
        if ($urandom_range(0, 199) == 0) wake_in[w] = ~wake_in[w];
      if (c == 20000) begin
        rst = 1'b1;
        trig_in = 1'b1; mode_in = 1'b1; wake_in = '0;
        @(negedge clk);
        @(negedge clk);
        chk("R1", "trig_lvl after mid reset", trig_lvl, 1'b1);
        chk("R1", "wake_evt after mid reset", wake_evt, 1'b0);
        rst = 1'b0;
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule